// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Transmitter

This block is the target half of a bidirectional single-wire debug link. It is used while the target returns one data bit to the host. The host opens every bit time by pulling the shared line low. The target brings that line into its own clock domain through a synchronizer and detects the falling edge there. It then either keeps the line low for a fixed number of cycles to send a 0, or leaves the line alone so that the pull-up returns it high to send a 1.

A 0 ends with a one-cycle high speedup pulse that sharpens the rising edge, after which the pad goes back to high impedance. The block presents a drive-enable and a drive value, so the pad can be wired as open-drain or as a push-pull output. A one-cycle done strobe marks the end of each bit time. Further falling edges are not acted on until the synchronized line has been seen high again.

Top module: `swtx_bit_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pad_oe`, `pad_out` and `bit_done` are all 0.
- R2: The raw line is synchronized through SYNC_STAGES flops (default 2). With `tx_en`=1 and `tx_bit`=0, `pad_oe` rises at clock edge SYNC_STAGES+1 after the edge that first samples the line low (edge 3 by default). It never rises without such a detected start.
- R3: For a 0 bit, the line is driven low (`pad_oe`=1, `pad_out`=0) for exactly LOW_CYCLES consecutive cycles (default 13).
- R4: The low period is followed directly by SPEED_CYCLES cycles (default 1) of `pad_oe`=1, `pad_out`=1. After that, `pad_oe` returns to 0.
- R5: With `tx_en`=1 and `tx_bit`=1, `pad_oe` stays 0 for the whole bit time.
- R6: With `tx_en`=0, a falling edge on the line is ignored: `pad_oe` stays 0 and `bit_done` is not pulsed.
- R7: `bit_done` is a one-cycle pulse. It is raised on the first edge at which the synchronized line is seen high once the bit has started. For a 0 bit this is edge 2*SYNC_STAGES+LOW_CYCLES+SPEED_CYCLES+1 (19 by default). For a 1 bit whose host low pulse lasts H cycles, it is edge H+SYNC_STAGES+1.
- R8: `tx_bit` is captured when the start is detected. Changing it later in the same bit has no effect on the drive.
- R9: Ten cycles after the host pulls the line low, the line level equals the bit being sent (low for 0, high for 1).
- R10: `pad_out` is never 1 while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_raw | input | 1 | Shared line level, asynchronous to `clk` |
| tx_en | input | 1 | Respond to host bit starts when 1 |
| tx_bit | input | 1 | Data bit to return to the host |
| pad_oe | output | 1 | Pad drive enable (0 = high impedance) |
| pad_out | output | 1 | Value driven when `pad_oe` is 1 |
| bit_done | output | 1 | One-cycle strobe at the end of a bit time |

## Verification
The bound checker tests on every cycle the rules that hold whatever the traffic:
- the drive value only appears under enable;
- a drive never starts without a detected, enabled start;
- the low run length and the speedup length are exact, using its own run counters;
- the done strobe lasts one cycle and follows a high synchronized line.

Only the bench scenarios can show the absolute latencies measured from the host's falling edge, the line level at the host's sample point, and that 1 bits and disabled starts produce no drive at all. The bench sweeps the host pulse width, the bit value and the enable, and computes each expected value from the parameters.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOW    = 2'd1,
    ST_SPEED  = 2'd2,
    ST_WAITHI = 2'd3
  } swtx_state_e;

  // Width needed to count 0..n-1 (at least 1 bit)
  function automatic int unsigned swtx_cnt_w(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w = w + 1;
    return w;
  endfunction

  // True when the running count is on the last cycle of a phase of 'len' cycles
  function automatic logic swtx_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Edge index (counting from the edge that first samples the line low)
  // at which the drive for a 0 bit begins
  function automatic int unsigned swtx_drive_edge(input int unsigned sync_stages);
    return sync_stages + 1;
  endfunction

endpackage

// File: rtl/swtx_sync.sv
module swtx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync,
  output logic fall_evt
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES-1];
  end

  assign line_sync = chain[STAGES-1];
  assign fall_evt  = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/swtx_seq.sv
module swtx_seq
  import swtx_pkg::*;
#(
  parameter int unsigned LOW_CYCLES   = 13,
  parameter int unsigned SPEED_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fall_evt,
  input  logic        line_sync,
  input  logic        tx_en,
  input  logic        tx_bit,
  output swtx_state_e state,
  output logic        bit_done,
  output logic        start_zero,
  output logic        start_one
);

  localparam int unsigned PHASE_MAX = (LOW_CYCLES > SPEED_CYCLES) ? LOW_CYCLES : SPEED_CYCLES;
  localparam int unsigned CNT_W     = swtx_cnt_w(PHASE_MAX);

  swtx_state_e        state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;

  assign start_zero = (state_q == ST_IDLE) && fall_evt && tx_en && !tx_bit;
  assign start_one  = (state_q == ST_IDLE) && fall_evt && tx_en &&  tx_bit;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_zero)     state_d = ST_LOW;
        else if (start_one) state_d = ST_WAITHI;
      end
      ST_LOW: begin
        if (swtx_last(int'(cnt_q), LOW_CYCLES)) begin
          state_d = ST_SPEED;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SPEED: begin
        if (swtx_last(int'(cnt_q), SPEED_CYCLES)) begin
          state_d = ST_WAITHI;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAITHI: begin
        if (line_sync) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign state    = state_q;
  assign bit_done = done_q;

endmodule

// File: rtl/swtx_drive.sv
module swtx_drive
  import swtx_pkg::*;
(
  input  swtx_state_e state,
  output logic        pad_oe,
  output logic        pad_out
);

  always_comb begin
    pad_oe  = 1'b0;
    pad_out = 1'b0;
    unique case (state)
      ST_LOW:   begin pad_oe = 1'b1; pad_out = 1'b0; end
      ST_SPEED: begin pad_oe = 1'b1; pad_out = 1'b1; end
      default:  begin pad_oe = 1'b0; pad_out = 1'b0; end
    endcase
  end

endmodule

// File: rtl/swtx_bit_tx.sv
module swtx_bit_tx
  import swtx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LOW_CYCLES   = 13,
  parameter int unsigned SPEED_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  input  logic tx_en,
  input  logic tx_bit,
  output logic pad_oe,
  output logic pad_out,
  output logic bit_done
);

  // Named internal events, visible to the bound checker
  logic        line_sync;
  logic        fall_evt;
  logic        start_zero;
  logic        start_one;
  swtx_state_e state;

  swtx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_raw  (line_raw),
    .line_sync (line_sync),
    .fall_evt  (fall_evt)
  );

  swtx_seq #(
    .LOW_CYCLES   (LOW_CYCLES),
    .SPEED_CYCLES (SPEED_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_evt   (fall_evt),
    .line_sync  (line_sync),
    .tx_en      (tx_en),
    .tx_bit     (tx_bit),
    .state      (state),
    .bit_done   (bit_done),
    .start_zero (start_zero),
    .start_one  (start_one)
  );

  swtx_drive u_drive (
    .state   (state),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

endmodule

// File: rtl/swtx_checker.sv
module swtx_checker #(
  parameter int unsigned LOW_CYCLES   = 13,
  parameter int unsigned SPEED_CYCLES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic pad_oe,
  input logic pad_out,
  input logic bit_done,
  input logic line_sync,
  input logic start_zero
);

  logic [15:0] low_run;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      hi_run  <= '0;
    end else begin
      if (pad_oe && !pad_out) begin
        if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
      end else if (!pad_oe) begin
        low_run <= '0;
      end
      if (pad_out) begin
        if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
      end else if (!pad_oe) begin
        hi_run <= '0;
      end
    end
  end

  AST_VALUE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out |-> pad_oe); // R10

  AST_DRIVE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(start_zero)); // R2

  AST_DRIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(tx_en)); // R6

  AST_LOW_RUN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_out) |-> (low_run == 16'(LOW_CYCLES))); // R3

  AST_SPEEDUP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_out) |-> ($past(pad_oe) && !$past(pad_out))); // R4

  AST_SPEEDUP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_out) |-> (!pad_oe && hi_run == 16'(SPEED_CYCLES))); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done); // R7

  AST_DONE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $past(line_sync)); // R7

endmodule

bind swtx_bit_tx swtx_checker #(
  .LOW_CYCLES   (LOW_CYCLES),
  .SPEED_CYCLES (SPEED_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .bit_done   (bit_done),
  .line_sync  (line_sync),
  .start_zero (start_zero)
);

// File: tb/swtx_bit_tx_test.sv
`timescale 1ns/1ps
module swtx_bit_tx_test;

  localparam int SYNC  = 2;
  localparam int LOWC  = 13;
  localparam int SPDC  = 1;
  localparam int WIN   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b0;
  logic pad_oe, pad_out, bit_done;
  logic line;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // Wired line: host pulls low, otherwise target drive or pull-up
  assign line = host_low ? 1'b0 : (pad_oe ? pad_out : 1'b1);

  swtx_bit_tx #(.SYNC_STAGES(SYNC), .LOW_CYCLES(LOWC), .SPEED_CYCLES(SPDC)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (line),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .bit_done (bit_done)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected values restated from the requirements
  function automatic int exp_first_drive();
    return SYNC + 1;
  endfunction
  function automatic int exp_done_zero();
    return 2 * SYNC + LOWC + SPDC + 1;
  endfunction
  function automatic int exp_done_one(input int h);
    return h + SYNC + 1;
  endfunction

  // One host bit time: host low for h cycles; optional flip of tx_bit mid-bit
  task automatic run_bit(input logic bitv, input logic en, input int h, input logic flip);
    int first_oe = -1, low_n = 0, hi_n = 0, hi_at = -1, last_oe = -1;
    int done_at = -1, done_n = 0, line10 = -1, bad_order = 0;
    @(negedge clk);
    tx_bit   = bitv;
    tx_en    = en;
    host_low = 1'b1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (pad_oe && first_oe < 0) first_oe = k;
      if (pad_oe) last_oe = k;
      if (pad_oe && !pad_out) begin
        low_n++;
        if (hi_n != 0) bad_order++;
      end
      if (pad_out) begin
        hi_n++;
        hi_at = k;
        if (!pad_oe) bad_order++;
      end
      if (bit_done) begin
        done_n++;
        if (done_at < 0) done_at = k;
      end
      if (k == 10) line10 = int'(line);
      if (k == h) host_low = 1'b0;
      if (flip && k == 5) tx_bit = ~bitv;
    end
    host_low = 1'b0;
    if (!en) begin
      check("R6", low_n + hi_n, 0, "drive cycles with tx_en=0");
      check("R6", done_n, 0, "done pulses with tx_en=0");
    end else if (!bitv) begin
      check("R2", first_oe, exp_first_drive(), "first drive edge");
      check("R3", low_n, LOWC, flip ? "low cycles (R8 flip)" : "low cycles");
      check("R4", hi_n, SPDC, "speedup cycles");
      check("R4", hi_at, exp_first_drive() + LOWC + SPDC - 1, "speedup position");
      check("R4", last_oe, hi_at, "release after speedup");
      check("R10", bad_order, 0, "order/value-without-oe violations");
      check("R9", line10, 0, "line at host sample point");
      check("R7", done_at, exp_done_zero(), "done edge for 0");
      check("R7", done_n, 1, "done pulse count for 0");
    end else begin
      check("R5", low_n + hi_n, 0, "drive cycles for 1");
      check("R9", line10, (h < 10) ? 1 : 0, "line at host sample point");
      check("R7", done_at, exp_done_one(h), "done edge for 1");
      check("R7", done_n, 1, "done pulse count for 1");
    end
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {29'd0, pad_oe, pad_out, bit_done}, 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'd0, pad_oe, pad_out, bit_done}, 0, "outputs after reset");
    repeat (2) @(negedge clk);

    for (int h = 3; h <= 8; h++) run_bit(1'b0, 1'b1, h, 1'b0);
    for (int h = 1; h <= 8; h++) run_bit(1'b1, 1'b1, h, 1'b0);
    for (int h = 1; h <= 4; h++) begin
      run_bit(1'b0, 1'b0, h + 2, 1'b0);
      run_bit(1'b1, 1'b0, h, 1'b0);
    end
    run_bit(1'b0, 1'b1, 4, 1'b1);   // R8: flip to 1 mid-bit
    run_bit(1'b1, 1'b1, 4, 1'b1);   // R8: flip to 0 mid-bit, still no drive
    run_bit(1'b0, 1'b1, 3, 1'b0);   // back-to-back after flips

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule